// File: doc/BRIEF.md
# Quad-Rate Four-Word Burst Static Memory Model

This block is a synthesizable behavioural model of a static memory with a separate write data bus and read data bus. Every transfer moves a burst of four words. The block stands in for an external memory inside a larger simulation or emulation netlist, and it keeps the interface timing of the real device.

The block runs from one fast clock that carries two phases per memory clock period. Input `phase_a` marks the edges that stand for the rising edge of the main memory clock (phase A). All other edges stand for the rising edge of the complementary clock (phase B). Commands are sampled only on phase A. Write data is captured on both phases, and read data is returned on both phases. Input `clk_run` models a stopped memory clock: while it is low, nothing in the block moves. A valid flag and zeroed read data stand in for an output that is not driven.

The address selects a group of four aligned words. The two word-offset bits count 0, 1, 2, 3 inside the block. Phase index P is the enabled edge at which a request is accepted. Phases are counted only on edges where `clk_run` is high.

Top module: `qdr_b4_sram`

## Requirements
- R1: `rd_sel_n`, `wr_sel_n` and `grp_addr` are sampled only on an enabled edge with `phase_a`=1. A select low on a phase-B edge has no effect.
- R2: An accepted write captures `wdata` at enabled edges P+2, P+3, P+4 and P+5 into word addresses {A,00}, {A,01}, {A,10} and {A,11}.
- R3: After an accepted read, `rdata` holds words {A,00} through {A,11} after enabled edges P+5 to P+8, in that order. `rdata_vld` is 1 exactly during those four phases.
- R4: `byte_wen_n[i]`=0 writes byte lane i (`wdata[8i+7:8i]`) of the captured word. A value of 1 leaves that stored byte unchanged.
- R5: A request is accepted only if its select was high at the previous phase-A edge. A second or further same-type request on consecutive phase-A edges is ignored.
- R6: With both selects high, `wdata` and `byte_wen_n` outside a write burst change nothing. When `rdata_vld` is 0, `rdata` is all zeros.
- R7: After reset `rdata_vld` is 0 and `rdata` is 0. Both selects count as previously high, so a request on the first phase-A edge is accepted.
- R8: While `clk_run` is 0, the stored words, `rdata`, `rdata_vld` and all burst progress are held unchanged.
- R9: A read and a write may be accepted on the same phase-A edge or may overlap. Each read word returns the stored contents as they stand just before its output edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, two edges per memory clock period |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_run | input | 1 | High when the modelled memory clock is running |
| phase_a | input | 1 | 1 = this edge is the main clock rise (command phase) |
| rd_sel_n | input | 1 | Active-low read request |
| wr_sel_n | input | 1 | Active-low write request |
| grp_addr | input | GRP_W | Four-word group address |
| wdata | input | DATA_W | Write data word |
| byte_wen_n | input | DATA_W/8 | Active-low byte lane write enables |
| rdata | output | DATA_W | Read data word, zero when not valid |
| rdata_vld | output | 1 | High while `rdata` carries a burst word |

## Verification
The assertions assume that `phase_a` alternates on every enabled edge and holds still while `clk_run` is low, so that phase-A edges are always two enabled edges apart. The bench derives `phase_a` from its own count of enabled edges, which keeps this rule by construction. Stopped-clock edges are inserted at random, including in the middle of bursts. Request patterns cover isolated requests, runs of two and three consecutive requests, and simultaneous read and write, and the bench also drives random selects on phase B.

// File: rtl/qdr_b4_pkg.sv
// Package: shared constants for the four-word burst memory model.
// Stage numbers count enabled edges after the accepting edge, less one.
package qdr_b4_pkg;
    localparam int BURST_LEN = 4;
    localparam int OFS_W     = $clog2(BURST_LEN);
    // write word 0 is captured from pipeline stage 1 (edge P+2)
    localparam int WR_LAG    = 1;
    // read word 0 is launched from pipeline stage 4 (edge P+5)
    localparam int RD_LAG    = 4;
endpackage

// File: rtl/qdr_b4_gate.sv
// Module: request gate for one request type.
// It accepts an active-low select on an enabled phase-A edge, but only when
// the same select was high on the previous phase-A edge.
// Assumes: phase_a alternates on enabled edges.
module qdr_b4_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_run,
    input  logic phase_a,
    input  logic sel_n,
    output logic acc
);
    logic prev_hi;

    // purpose: accept only a select that was idle on the previous phase-A edge
    always_comb acc = clk_run & phase_a & ~sel_n & prev_hi;

    // purpose: remember the select level from the last phase-A edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_hi <= 1'b1;
        else if (clk_run && phase_a)
            prev_hi <= sel_n;
    end
endmodule

// File: rtl/qdr_b4_pipe.sv
// Module: burst tracking pipeline.
// A shift register that advances on every enabled edge. It carries each
// accepted group address, and it picks the stage that is due at the current
// edge for word offsets 0..BURST_LEN-1.
// Assumes: accepted pushes are at least BURST_LEN enabled edges apart, so at
// most one due stage is valid.
module qdr_b4_pipe #(
    parameter int GRP_W = 6,
    parameter int LAG   = 1
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    clk_run,
    input  logic                                    push,
    input  logic [GRP_W-1:0]                        push_grp,
    output logic                                    hit,
    output logic [GRP_W+qdr_b4_pkg::OFS_W-1:0]      word_addr
);
    import qdr_b4_pkg::*;
    localparam int DEPTH = LAG + BURST_LEN;

    logic [DEPTH-1:0] vld;
    logic [GRP_W-1:0] grp [DEPTH];

    // purpose: advance burst entries by one stage per enabled edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (clk_run) begin
            vld <= {vld[DEPTH-2:0], push};
        end
    end

    // purpose: address payload moves with its valid bit, no reset needed
    always_ff @(posedge clk) begin
        if (clk_run) begin
            grp[0] <= push_grp;
            for (int s = 1; s < DEPTH; s++)
                grp[s] <= grp[s-1];
        end
    end

    // purpose: select the stage whose word is due now and form its word address
    always_comb begin
        hit       = 1'b0;
        word_addr = '0;
        for (int s = LAG; s < DEPTH; s++) begin
            if (vld[s]) begin
                hit       = 1'b1;
                word_addr = {grp[s], OFS_W'(s - LAG)};
            end
        end
    end
endmodule

// File: rtl/qdr_b4_store.sv
// Module: word array with byte lane writes and a registered read port.
// A read at an edge returns the contents as they stand before any write at
// the same edge. The array itself is not reset; the output register is.
module qdr_b4_store #(
    parameter int WA_W   = 8,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clk_run,
    input  logic                  we,
    input  logic [WA_W-1:0]       waddr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [DATA_W/8-1:0]   wbe_n,
    input  logic                  re,
    input  logic [WA_W-1:0]       raddr,
    output logic [DATA_W-1:0]     rdata,
    output logic                  rdata_vld
);
    localparam int NB    = DATA_W / 8;
    localparam int WORDS = 1 << WA_W;

    logic [DATA_W-1:0] mem [WORDS];

    // purpose: write enabled byte lanes of the captured word
    always_ff @(posedge clk) begin
        if (clk_run && we) begin
            for (int b = 0; b < NB; b++)
                if (!wbe_n[b])
                    mem[waddr][b*8 +: 8] <= wdata[b*8 +: 8];
        end
    end

    // purpose: launch a burst word or park the bus at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata     <= '0;
            rdata_vld <= 1'b0;
        end else if (clk_run) begin
            if (re) begin
                rdata     <= mem[raddr];
                rdata_vld <= 1'b1;
            end else begin
                rdata     <= '0;
                rdata_vld <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/qdr_b4_sram.sv
// Module: top of the four-word burst quad-rate memory model.
// Two request gates feed two burst pipelines with different lags. The write
// pipeline steers captured words into the store, and the read pipeline
// launches words from it.
// Assumes: phase_a alternates on enabled edges; clk_run low freezes all state.
module qdr_b4_sram #(
    parameter int GRP_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clk_run,
    input  logic                 phase_a,
    input  logic                 rd_sel_n,
    input  logic                 wr_sel_n,
    input  logic [GRP_W-1:0]     grp_addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [DATA_W/8-1:0]  byte_wen_n,
    output logic [DATA_W-1:0]    rdata,
    output logic                 rdata_vld
);
    import qdr_b4_pkg::*;
    localparam int WA_W = GRP_W + OFS_W;

    logic            rd_acc;
    logic            wr_acc;
    logic            rd_hit;
    logic            wr_hit;
    logic [WA_W-1:0] rd_word;
    logic [WA_W-1:0] wr_word;

    qdr_b4_gate i_rd_gate (
        .clk(clk), .rst_n(rst_n), .clk_run(clk_run), .phase_a(phase_a),
        .sel_n(rd_sel_n), .acc(rd_acc)
    );

    qdr_b4_gate i_wr_gate (
        .clk(clk), .rst_n(rst_n), .clk_run(clk_run), .phase_a(phase_a),
        .sel_n(wr_sel_n), .acc(wr_acc)
    );

    qdr_b4_pipe #(.GRP_W(GRP_W), .LAG(WR_LAG)) i_wr_pipe (
        .clk(clk), .rst_n(rst_n), .clk_run(clk_run),
        .push(wr_acc), .push_grp(grp_addr),
        .hit(wr_hit), .word_addr(wr_word)
    );

    qdr_b4_pipe #(.GRP_W(GRP_W), .LAG(RD_LAG)) i_rd_pipe (
        .clk(clk), .rst_n(rst_n), .clk_run(clk_run),
        .push(rd_acc), .push_grp(grp_addr),
        .hit(rd_hit), .word_addr(rd_word)
    );

    qdr_b4_store #(.WA_W(WA_W), .DATA_W(DATA_W)) i_store (
        .clk(clk), .rst_n(rst_n), .clk_run(clk_run),
        .we(wr_hit), .waddr(wr_word), .wdata(wdata), .wbe_n(byte_wen_n),
        .re(rd_hit), .raddr(rd_word),
        .rdata(rdata), .rdata_vld(rdata_vld)
    );
endmodule

// File: rtl/qdr_b4_sram_chk.sv
// Module: protocol checker for qdr_b4_sram, attached by bind below.
// Assumes: phase_a alternates on enabled edges.
module qdr_b4_sram_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_run,
    input logic              phase_a,
    input logic              rd_acc,
    input logic              wr_acc,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_vld
);
    logic       rd_last;
    logic       wr_last;
    logic [1:0] vcnt;
    logic       vseen;

    // purpose: note whether each request type was accepted on the last phase-A edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_last <= 1'b0;
            wr_last <= 1'b0;
        end else if (clk_run && phase_a) begin
            rd_last <= rd_acc;
            wr_last <= wr_acc;
        end
    end

    // purpose: count enabled phases of each valid run, modulo four
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vcnt  <= '0;
            vseen <= 1'b0;
        end else if (clk_run) begin
            if (rdata_vld) begin
                vcnt  <= vcnt + 2'd1;
                vseen <= 1'b1;
            end else begin
                vcnt  <= '0;
                vseen <= 1'b0;
            end
        end
    end

    // R5: no read accepted right after an accepted read
    a_r5_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_run && phase_a && rd_last) |-> !rd_acc);

    // R5: no write accepted right after an accepted write
    a_r5_write_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_run && phase_a && wr_last) |-> !wr_acc);

    // R8: a stopped edge leaves the read outputs unchanged
    a_r8_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_run |=> ($stable(rdata) && $stable(rdata_vld)));

    // R6: the data bus is parked at zero when not valid
    a_r6_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_vld |-> (rdata == '0));

    // R3: every valid run lasts a whole number of four-word bursts
    a_r3_burst_four: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_run && !rdata_vld && vseen) |-> (vcnt == 2'd0));

    // R7: outputs are quiet on the first edge after reset
    a_r7_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !rdata_vld);
endmodule

bind qdr_b4_sram qdr_b4_sram_chk #(.DATA_W(DATA_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .clk_run(clk_run), .phase_a(phase_a),
    .rd_acc(rd_acc), .wr_acc(wr_acc), .rdata(rdata), .rdata_vld(rdata_vld)
);

// File: tb/test_qdr_b4_sram.sv
`timescale 1ns/1ps
// Bench: directed corner cases followed by seeded random traffic. An
// edge-accurate word model in the bench predicts every output phase.
module test_qdr_b4_sram;
    localparam int GRP_W  = 6;
    localparam int DATA_W = 16;
    localparam int NB     = DATA_W / 8;
    localparam int WA_W   = GRP_W + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clk_run = 1'b0;
    logic              phase_a = 1'b1;
    logic              rd_sel_n = 1'b1;
    logic              wr_sel_n = 1'b1;
    logic [GRP_W-1:0]  grp_addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [NB-1:0]     byte_wen_n = '1;
    logic [DATA_W-1:0] rdata;
    logic              rdata_vld;

    qdr_b4_sram #(.GRP_W(GRP_W), .DATA_W(DATA_W)) i_qdr_b4_sram (
        .clk(clk), .rst_n(rst_n), .clk_run(clk_run), .phase_a(phase_a),
        .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n), .grp_addr(grp_addr),
        .wdata(wdata), .byte_wen_n(byte_wen_n),
        .rdata(rdata), .rdata_vld(rdata_vld)
    );

    always #2.5 clk = ~clk;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    int  n = 0;
    bit  full_bytes = 0;
    bit  prev_r = 1, prev_w = 1;
    logic [DATA_W-1:0] mem_m [1 << WA_W];
    bit                rd_on [32];
    int                rd_wa [32];
    bit                wr_on [32];
    int                wr_wa [32];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old,
            input logic [DATA_W-1:0] nw, input logic [NB-1:0] be_n);
        logic [DATA_W-1:0] r = old;
        for (int b = 0; b < NB; b++)
            if (!be_n[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        return r;
    endfunction

    // one edge: drive inputs, update the model, then check outputs after the edge
    task automatic phase(input bit run, input bit rs_n, input bit ws_n, input int grp);
        logic [DATA_W-1:0] hq;
        logic              hv;
        int                slot;
        logic [DATA_W-1:0] e;
        clk_run    = run;
        phase_a    = (n % 2 == 0);
        rd_sel_n   = rs_n;
        wr_sel_n   = ws_n;
        grp_addr   = GRP_W'(grp);
        wdata      = DATA_W'($urandom);
        byte_wen_n = full_bytes ? '0 : NB'($urandom);
        if (run) begin
            slot = n % 32;
            if (wr_on[slot]) begin
                mem_m[wr_wa[slot]] = merge(mem_m[wr_wa[slot]], wdata, byte_wen_n);
                wr_on[slot] = 0;
            end
            if (phase_a) begin
                if (!rs_n && prev_r)
                    for (int j = 0; j < 4; j++) begin
                        rd_on[(n + 5 + j) % 32] = 1;
                        rd_wa[(n + 5 + j) % 32] = (grp % 64) * 4 + j;
                    end
                if (!ws_n && prev_w)
                    for (int j = 0; j < 4; j++) begin
                        wr_on[(n + 2 + j) % 32] = 1;
                        wr_wa[(n + 2 + j) % 32] = (grp % 64) * 4 + j;
                    end
                prev_r = rs_n;
                prev_w = ws_n;
            end
        end
        hq = rdata;
        hv = rdata_vld;
        @(posedge clk);
        @(negedge clk);
        if (run) begin
            slot = n % 32;
            check(rdata_vld === rd_on[slot], "R1 R3 R5 R7", "valid flag",
                  32'(rdata_vld), 32'(rd_on[slot]));
            e = rd_on[slot] ? mem_m[rd_wa[slot]] : '0;
            check(rdata === e, rd_on[slot] ? "R2 R3 R4 R9" : "R6", "read data",
                  32'(rdata), 32'(e));
            rd_on[slot] = 0;
            n++;
        end else begin
            check(rdata === hq && rdata_vld === hv, "R8", "held outputs",
                  {15'd0, rdata_vld, rdata}, {15'd0, hv, hq});
        end
    endtask

    // one memory clock period: phase A with the command, phase B with random selects
    task automatic kcycle(input bit rs_n, input bit ws_n, input int grp);
        phase(1, rs_n, ws_n, grp);
        phase(1, bit'($urandom), bit'($urandom), int'($urandom % 64));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h51a7));
        for (int i = 0; i < 32; i++) begin rd_on[i] = 0; wr_on[i] = 0; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: quiet outputs out of reset (no enabled edge yet)
        check(rdata_vld === 1'b0 && rdata === '0, "R7", "reset outputs",
              {15'd0, rdata_vld, rdata}, 32'd0);

        // R2 R7: full-word writes to groups 0..7, first one on the first phase-A edge
        full_bytes = 1;
        for (int g = 0; g < 8; g++) begin kcycle(1, 0, g); kcycle(1, 1, 0); end
        full_bytes = 0;
        repeat (4) kcycle(1, 1, 0);

        // R3: read back each group
        for (int g = 0; g < 8; g++) begin kcycle(0, 1, g); kcycle(1, 1, 0); end
        repeat (5) kcycle(1, 1, 0);

        // R5: a run of three reads, only the first is taken, then a gapped one
        kcycle(0, 1, 2); kcycle(0, 1, 5); kcycle(0, 1, 6); kcycle(1, 1, 0);
        kcycle(0, 1, 7);
        repeat (5) kcycle(1, 1, 0);

        // R5 R4: back-to-back writes with random byte lanes, then read both groups
        kcycle(1, 0, 4); kcycle(1, 0, 1); kcycle(1, 1, 0);
        kcycle(0, 1, 4); kcycle(1, 1, 0); kcycle(0, 1, 1);
        repeat (5) kcycle(1, 1, 0);

        // R9: read and write of one group on the same phase-A edge
        kcycle(0, 0, 3); kcycle(1, 1, 0); kcycle(0, 1, 3);
        repeat (5) kcycle(1, 1, 0);

        // R8: stop the clock in the middle of a read burst
        kcycle(0, 1, 6); kcycle(1, 1, 0);
        phase(1, 1, 1, 0);
        phase(1, 0, 0, 9);
        for (int s = 0; s < 3; s++) phase(0, 0, 0, 5);
        phase(1, 1, 1, 0);
        repeat (5) kcycle(1, 1, 0);
        kcycle(0, 1, 5);
        repeat (5) kcycle(1, 1, 0);

        // random traffic with random stops
        for (int k = 0; k < 3000; k++) begin
            phase(1, ($urandom % 3) != 0, ($urandom % 3) != 0, int'($urandom % 12));
            if ($urandom % 8 == 0) phase(0, bit'($urandom), bit'($urandom), 0);
            phase(1, bit'($urandom), bit'($urandom), int'($urandom % 64));
        end
        repeat (6) kcycle(1, 1, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule